// File: doc/BRIEF.md
# Linked-List DMA Node Walker

This block is a DMA sequencer that walks a chain of nodes held in RAM and streams their payload to a device. Software places the address of the first node on the start-address input and pulses the start strobe. The walker reads the node's header word, sends the number of payload words the header names to the device port, one word in each cycle the device is ready, and then follows the header's next-node pointer to the following header.

The chain ends at an end marker. A mode input chooses how the marker is recognised: either any pointer with its top address bit set, or only the all-ones pointer. The mode is sampled together with the start strobe. Between nodes the walker spends one cycle with no memory request, which leaves a gap for other bus users. It pulses an output after every node and pulses a second output when the marker is seen. At that point the busy flag drops by itself and the address register holds the marker.

Top module: `list_dma_walker`

## Requirements
- R1: A start strobe while idle latches the start address with bits 1..0 cleared and raises busy. In the next cycle the walker issues a memory read at that address, which is the header fetch.
- R2: A header word carries the payload word count in bits 31..24 and the next-node pointer in bits 23..0. Memory read data is combinational: it belongs to the address driven in the same cycle.
- R3: After a header, exactly the count of words that follow it are sent to the device, in rising address order, one per cycle while device ready is high. Device valid is high only when ready is high and a memory read is issued, and the data it carries is the word just read.
- R4: A header with a count of zero sends no payload words. The walker goes straight on to the next node.
- R5: Every memory read address has bits 1..0 at zero. A followed pointer has its bits 1..0 cleared.
- R6: Each node ends with one cycle in which the node-done pulse is high and no memory read is issued.
- R7: With the marker mode input low at start, any next pointer with bit 23 set ends the walk.
- R8: With the marker mode input high at start, only the pointer FFFFFFh ends the walk. Other pointers with bit 23 set are followed.
- R9: At the end marker, list-done pulses in the same cycle as the last node-done. In the next cycle busy is low and the current-address output holds the marker exactly as fetched.
- R10: A start strobe while busy has no effect on the walk.
- R11: With device ready held high, a chain of nodes with counts k_i takes the sum of (k_i + 2) cycles, counted from the cycle after start to the list-done cycle inclusive.
- R12: After reset the walker is idle, with busy, memory read, device valid, node-done and list-done all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe |
| start_addr_i | input | 24 | Address of the first header |
| marker_all_ones_i | input | 1 | 0: bit 23 set ends the walk; 1: only FFFFFFh ends it |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Memory read this cycle |
| mem_addr_o | output | 24 | Memory read address |
| mem_rdata_i | input | 32 | Memory read data for mem_addr_o |
| dev_valid_o | output | 1 | Payload word presented to the device |
| dev_data_o | output | 32 | Payload word |
| dev_ready_i | input | 1 | Device accepts a word this cycle |
| cur_addr_o | output | 24 | Current address register |
| node_done_o | output | 1 | Pulse at the end of each node |
| list_done_o | output | 1 | Pulse when the end marker is reached |

## Verification
The bench builds the block with its default 24-bit pointers and 8-bit counts, and backs it with a 256-word memory that decodes only address bits 9..2. Pointers with bit 23 set therefore still reach real nodes, which is what brings the difference between the two marker modes within reach. It sweeps chains of one to four nodes with every count from zero to three, misaligned pointers, both marker modes, several device-ready duty patterns and stray start strobes. One single node of 255 words covers the full count range.

// File: rtl/list_dma_walker.sv
module list_dma_walker #(
  parameter int AW = 24,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          marker_all_ones_i,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [AW+CW-1:0] mem_rdata_i,
  output logic          dev_valid_o,
  output logic [AW+CW-1:0] dev_data_o,
  input  logic          dev_ready_i,
  output logic [AW-1:0] cur_addr_o,
  output logic          node_done_o,
  output logic          list_done_o
);
  localparam int DW = AW + CW;
  localparam logic [AW-1:0] ALIGN = ~AW'(3);
  localparam logic [AW-1:0] STEP  = AW'(4);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_DATA, S_LINK} st_t;

  st_t           st;
  logic [AW-1:0] addr, nxt;
  logic [CW-1:0] cnt;
  logic          all_ones;

  wire at_end   = all_ones ? (&nxt) : nxt[AW-1];
  wire [CW-1:0] hdr_cnt = mem_rdata_i[DW-1:AW];

  assign busy_o      = st != S_IDLE;
  assign mem_req_o   = (st == S_HDR) || (st == S_DATA && dev_ready_i);
  assign mem_addr_o  = addr;
  assign cur_addr_o  = addr;
  assign dev_valid_o = (st == S_DATA) && dev_ready_i;
  assign dev_data_o  = mem_rdata_i;
  assign node_done_o = st == S_LINK;
  assign list_done_o = (st == S_LINK) && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr     <= '0;
      nxt      <= '0;
      cnt      <= '0;
      all_ones <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          addr     <= start_addr_i & ALIGN;
          all_ones <= marker_all_ones_i;
          st       <= S_HDR;
        end
        S_HDR: begin
          nxt  <= mem_rdata_i[AW-1:0];
          cnt  <= hdr_cnt;
          addr <= addr + STEP;
          st   <= (hdr_cnt == '0) ? S_LINK : S_DATA;
        end
        S_DATA: if (dev_ready_i) begin
          addr <= addr + STEP;
          cnt  <= cnt - 1'b1;
          if (cnt == CW'(1)) st <= S_LINK;
        end
        S_LINK: begin
          if (at_end) begin
            addr <= nxt;
            st   <= S_IDLE;
          end else begin
            addr <= nxt & ALIGN;
            st   <= S_HDR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/list_dma_walker_chk.sv
module list_dma_walker_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [AW-1:0] start_addr_i,
  input logic          busy_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          dev_valid_o,
  input logic          dev_ready_i,
  input logic [AW-1:0] cur_addr_o,
  input logic          node_done_o,
  input logic          list_done_o
);
  assert_start_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && mem_req_o && mem_addr_o == ($past(start_addr_i) & ~AW'(3))));

  assert_valid_needs_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid_o |-> (dev_ready_i && mem_req_o));

  assert_word_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid_o |=> cur_addr_o == $past(cur_addr_o) + AW'(4));

  assert_aligned_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  assert_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    node_done_o |-> (!mem_req_o && busy_o));

  assert_done_with_node_R9: assert property (@(posedge clk) disable iff (!rst_n)
    list_done_o |-> node_done_o);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    list_done_o |=> !busy_o);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_req_o && !dev_valid_o && !node_done_o));
endmodule

bind list_dma_walker list_dma_walker_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_list_dma_walker.sv
module test_list_dma_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] start_addr = '0;
  logic        mode = 1'b0;
  logic        busy, mem_req, dev_valid, node_done, list_done;
  logic        dev_ready = 1'b0;
  logic [23:0] mem_addr, cur_addr;
  logic [31:0] mem_rdata, dev_data;
  logic [31:0] mem [256];
  logic [31:0] exp_w [300];
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;
  assign mem_rdata = mem[mem_addr[9:2]];

  list_dma_walker i_list_dma_walker (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(start_addr),
    .marker_all_ones_i(mode), .busy_o(busy), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .dev_valid_o(dev_valid),
    .dev_data_o(dev_data), .dev_ready_i(dev_ready), .cur_addr_o(cur_addr),
    .node_done_o(node_done), .list_done_o(list_done));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_list(input int nn, input int seed, input bit md, input int rp,
                          input bit poke, input bit long_node);
    int w[4];
    int kk[4];
    int ne = 0, got = 0, nodes = 0, cyc = 0, done_cyc = 0, want_cyc = 0;
    bit bad_align = 0, bad_gap = 0, bad_rdy = 0, bad_data = 0, first_ok = 0;
    logic [23:0] endp, p;
    for (int k = 0; k < 256; k++) mem[k] = 32'hDEAD0000 | k;
    endp = md ? 24'hFFFFFF : (24'h800000 | 24'(seed * 20 + 3));
    for (int i = 0; i < nn; i++) begin
      w[i]  = long_node ? 0 : 16 * (3 - i) + 1;
      kk[i] = long_node ? 255 : (i * 3 + seed) % 4;
    end
    for (int i = 0; i < nn; i++) begin
      if (i == nn - 1) p = endp;
      else p = 24'(w[i+1] << 2) | 24'((i + seed) & 3) | ((md && i == 0) ? 24'h800000 : 24'h0);
      mem[w[i]] = {8'(kk[i]), p};
      for (int j = 0; j < kk[i]; j++) begin
        mem[w[i] + 1 + j] = 32'hA0000000 | (seed << 16) | (i << 12) | j;
        exp_w[ne] = mem[w[i] + 1 + j];
        ne++;
      end
      want_cyc += kk[i] + 2;
    end
    @(negedge clk);
    start = 1'b1; mode = md;
    start_addr = 24'(w[0] << 2) | 24'(seed & 3);
    @(negedge clk);
    start = 1'b0; mode = ~md;
    forever begin
      cyc++;
      dev_ready = (rp == 0) ? 1'b1 : ((cyc % rp) != 0);
      #1;
      if (cyc == 1) first_ok = busy && mem_req && (mem_addr == 24'(w[0] << 2));
      if (mem_req && mem_addr[1:0] != 2'b00) bad_align = 1;
      if (dev_valid) begin
        if (!dev_ready || !mem_req) bad_rdy = 1;
        if (got >= ne || dev_data !== exp_w[got]) bad_data = 1;
        got++;
      end
      if (node_done) begin
        nodes++;
        if (mem_req) bad_gap = 1;
      end
      if (poke && cyc == 2) begin start = 1'b1; start_addr = 24'h000044; end
      if (poke && cyc == 3) start = 1'b0;
      if (list_done) begin
        done_cyc = cyc;
        chk(node_done, "R9 list_done with node_done", node_done, 1);
        break;
      end
      if (cyc > 3000) break;
      @(negedge clk);
    end
    @(negedge clk);
    start = 1'b0;
    chk(first_ok, "R1 header fetch at start address", first_ok, 1);
    chk(!bad_align, "R5 aligned reads", bad_align, 0);
    chk(!bad_rdy, "R3 valid only with ready and read", bad_rdy, 0);
    chk(!bad_data && got == ne, "R3 R2 R4 payload stream (words seen)", got, ne);
    chk(nodes == nn && !bad_gap, "R6 node pulses with idle bus", nodes, nn);
    chk(done_cyc != 0, md ? "R8 walk ends at FFFFFF only" : "R7 walk ends at bit 23", done_cyc, 1);
    if (rp == 0) chk(done_cyc == want_cyc, "R11 cycle count", done_cyc, want_cyc);
    chk(!busy, "R9 busy clears", busy, 0);
    chk(cur_addr == endp, "R9 address holds marker", cur_addr, endp);
    if (poke) chk(!busy && got == ne, "R10 start while busy ignored", got, ne);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !dev_valid && !node_done && !list_done,
        "R12 reset state", {busy, mem_req, dev_valid, node_done, list_done}, 0);
    rst_n = 1'b1;
    for (int md = 0; md < 2; md++)
      for (int nn = 1; nn <= 4; nn++)
        for (int seed = 0; seed < 4; seed++)
          for (int r = 0; r < 3; r++)
            run_list(nn, seed, md[0], (r == 0) ? 0 : r + 1, seed == 1, 1'b0);
    run_list(1, 2, 1'b0, 0, 1'b0, 1'b1);
    run_list(1, 3, 1'b1, 3, 1'b1, 1'b1);
    summary();
    $finish;
  end
endmodule